// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a small single-accumulator processor. It fetches 16-bit words from an external synchronous memory with one cycle of read latency. It executes one instruction at a time. Each instruction then moves through a fixed sequence of states: fetch, a capture wait, execute, an optional operand wait, and an interrupt check. An instruction either references a memory location or names an I/O device. Both kinds carry their operand in the same 12-bit field.

At the interrupt check the block looks at a level-sensitive request line. If a request is present and interrupts are enabled, the block acknowledges it. It stores the return address and the accumulator in two fixed memory words and continues at a fixed handler address. A return opcode reads both words back and enables interrupts again. A halt opcode parks the machine until reset, which lets a surrounding system see when a program has ended.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and directly after it, the program counter is 0x300. `mem_addr` shows 0x300, and `mem_we`, `io_rd`, `io_wr`, `irq_ack` and `halted` are all low.
- R2: An instruction carries its opcode in bits 15:12 and an address or device number in bits 11:0. A fetch reads the word at the program counter into the instruction register and advances the program counter by one.
- R3: Opcode 1 loads the accumulator from memory, opcode 5 adds a memory word to it, and opcode 2 writes it to memory. The program 0x300: 1940, 0x301: 5941, 0x302: 2941, with 0x940 = 0003 and 0x941 = 0002, leaves 0005 at 0x941.
- R4: Opcode 3 raises `io_rd` for one cycle with `io_dev` equal to bits 11:0, and the accumulator takes `io_din` from that cycle.
- R5: Opcode 7 raises `io_wr` for one cycle with `io_dev` equal to bits 11:0 and `io_dout` equal to the accumulator.
- R6: The block samples `irq` after each instruction. When `irq` is high and interrupts are enabled:
  - `irq_ack` pulses for one cycle;
  - in that cycle the return address (zero-extended) is written to 0x0FE;
  - in the next cycle the accumulator is written to 0x0FF;
  - fetching then resumes at 0x100.
- R7: Entering the interrupt cycle disables interrupts, so a request held high gives no further acknowledge. This lasts until opcode F runs. Opcode F reloads the program counter from 0x0FE and the accumulator from 0x0FF and enables interrupts again. A request still pending at that point is taken right after the return.
- R8: Opcodes other than 0, 1, 2, 3, 5, 7 and F do nothing. They cause no memory write and no I/O strobe, and execution goes on to the next word.
- R9: Opcode 0 raises `halted`. From then until reset there is no memory write, no I/O strobe and no acknowledge.
- R10: The add result wraps modulo 2^16.
- R11: In any cycle at most one of `mem_we`, `io_rd` and `io_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Data to write into memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| io_dev | output | 12 | Device number, taken from bits 11:0 of the instruction |
| io_dout | output | 16 | Accumulator value sent to a device |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| io_din | input | 16 | Data returned by a device while `io_rd` is high |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle acknowledge on entry to the interrupt cycle |
| halted | output | 1 | High once a halt opcode has executed |

## Verification
A return from interrupt and the next interrupt check can meet in back-to-back cycles. The return re-enables interrupts, and the check that follows at once must take a request that is still pending. To provoke this, the bench holds `irq` high through a whole handler and drops it only after the second acknowledge. The scoreboard then expects the same pair of context writes twice: 0x0301 to 0x0FE and A002 to 0x0FF. It also expects the handler's device write twice, and no acknowledge while the handler runs. Once the second handler returns, the interrupted program must write A002 to device 4, which shows that the restored accumulator is correct.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 12,
  parameter logic [AW-1:0] RESET_PC = 'h300,
  parameter logic [AW-1:0] ISR_PC   = 'h100,
  parameter logic [AW-1:0] SAVE_PC  = 'h0FE,
  parameter logic [AW-1:0] SAVE_AC  = 'h0FF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [AW+3:0] mem_wdata,
  output logic          mem_we,
  input  logic [AW+3:0] mem_rdata,
  output logic [AW-1:0] io_dev,
  output logic [AW+3:0] io_dout,
  output logic          io_rd,
  output logic          io_wr,
  input  logic [AW+3:0] io_din,
  input  logic          irq,
  output logic          irq_ack,
  output logic          halted
);
  localparam int DW = AW + 4;

  localparam logic [3:0] OP_HLT = 4'h0, OP_LDA = 4'h1, OP_STA = 4'h2, OP_IN = 4'h3,
                         OP_ADD = 4'h5, OP_OUT = 4'h7, OP_RTI = 4'hF;

  typedef enum logic [3:0] {
    S_FETCH, S_FWAIT, S_EXEC, S_OWAIT, S_CHECK,
    S_SAVEPC, S_SAVEAC, S_RPC, S_RAC, S_HALT
  } state_t;

  state_t        st;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, ac;
  logic          ie;

  wire [3:0]    op    = ir[DW-1:AW];
  wire [AW-1:0] field = ir[AW-1:0];

  assign io_dev  = field;
  assign io_dout = ac;
  assign halted  = (st == S_HALT);

  always_comb begin
    mem_addr  = pc;
    mem_wdata = ac;
    mem_we    = 1'b0;
    io_rd     = 1'b0;
    io_wr     = 1'b0;
    irq_ack   = 1'b0;
    case (st)
      S_EXEC: case (op)
        OP_LDA, OP_ADD: mem_addr = field;
        OP_STA: begin mem_addr = field; mem_we = 1'b1; end
        OP_IN:  io_rd = 1'b1;
        OP_OUT: io_wr = 1'b1;
        OP_RTI: mem_addr = SAVE_PC;
        default: ;
      endcase
      S_SAVEPC: begin
        mem_addr  = SAVE_PC;
        mem_wdata = {{(DW-AW){1'b0}}, pc};
        mem_we    = 1'b1;
        irq_ack   = 1'b1;
      end
      S_SAVEAC: begin mem_addr = SAVE_AC; mem_we = 1'b1; end
      S_RPC:    mem_addr = SAVE_AC;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH;
      pc <= RESET_PC;
      ir <= '0;
      ac <= '0;
      ie <= 1'b1;
    end else begin
      case (st)
        S_FETCH: st <= S_FWAIT;
        S_FWAIT: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        S_EXEC: case (op)
          OP_LDA, OP_ADD: st <= S_OWAIT;
          OP_IN:  begin ac <= io_din; st <= S_CHECK; end
          OP_RTI: st <= S_RPC;
          OP_HLT: st <= S_HALT;
          default: st <= S_CHECK;
        endcase
        S_OWAIT: begin
          ac <= (op == OP_ADD) ? ac + mem_rdata : mem_rdata;
          st <= S_CHECK;
        end
        S_RPC: begin
          pc <= mem_rdata[AW-1:0];
          st <= S_RAC;
        end
        S_RAC: begin
          ac <= mem_rdata;
          ie <= 1'b1;
          st <= S_CHECK;
        end
        S_CHECK: begin
          if (irq && ie) begin
            ie <= 1'b0;
            st <= S_SAVEPC;
          end else begin
            st <= S_FETCH;
          end
        end
        S_SAVEPC: st <= S_SAVEAC;
        S_SAVEAC: begin
          pc <= ISR_PC;
          st <= S_FETCH;
        end
        S_HALT: st <= S_HALT;
        default: st <= S_FETCH;
      endcase
    end
  end
endmodule

module acc_cpu_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] SAVE_PC = 'h0FE,
  parameter logic [AW-1:0] SAVE_AC = 'h0FF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          io_rd,
  input logic          io_wr,
  input logic          irq,
  input logic          irq_ack,
  input logic          halted
);
  assert_ack_saves_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (mem_we && mem_addr == SAVE_PC));

  assert_ack_then_ac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (mem_we && mem_addr == SAVE_AC));

  assert_ack_follows_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(irq));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  assert_halt_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !io_rd && !io_wr && !irq_ack));

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_we, io_rd, io_wr}) <= 1);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .SAVE_PC(SAVE_PC), .SAVE_AC(SAVE_AC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .io_rd(io_rd), .io_wr(io_wr), .irq(irq), .irq_ack(irq_ack), .halted(halted)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] mem_addr, io_dev;
  logic [DW-1:0] mem_wdata, mem_rdata, io_din, io_dout;
  logic mem_we, io_rd, io_wr, irq_ack, halted;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end
  assign io_din = 16'hA000 | {4'h0, io_dev};

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .io_dev(io_dev), .io_dout(io_dout),
    .io_rd(io_rd), .io_wr(io_wr), .io_din(io_din), .irq(irq),
    .irq_ack(irq_ack), .halted(halted)
  );

  int checks = 0, fails = 0, acks = 0;
  bit multi = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  localparam int K_MEM = 0, K_OUT = 1, K_IN = 2, K_ACK = 3;

  function automatic logic [31:0] item(int k, logic [11:0] a, logic [15:0] d);
    return {k[1:0], 2'b00, a, d};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_ev(int k, logic [11:0] a, logic [15:0] d, string tag);
    exp_q.push_back(item(k, a, d));
    tag_q.push_back(tag);
  endtask

  task automatic observe(logic [31:0] got);
    if (exp_q.size() == 0) check(1'b0, "R8/R9 unexpected bus event", got, 32'h0);
    else begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(got == e, t, got, e);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if ($countones({mem_we, io_rd, io_wr}) > 1) multi = 1'b1;
      if (irq_ack) begin acks++; observe(item(K_ACK, 0, 0)); end
      if (mem_we) observe(item(K_MEM, mem_addr, mem_wdata));
      if (io_rd) observe(item(K_IN, io_dev, 0));
      if (io_wr) observe(item(K_OUT, io_dev, io_dout));
    end
  end

  task automatic start();
    rst_n = 1'b0;
    irq = 1'b0;
    acks = 0;
    multi = 1'b0;
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(mem_addr == 12'h300, "R1 first fetch address", mem_addr, 12'h300);
    check(!mem_we && !io_rd && !io_wr, "R1 strobes low", {mem_we, io_rd, io_wr}, 0);
    check(!irq_ack && !halted, "R1 ack and halted low", {irq_ack, halted}, 0);
  endtask

  task automatic finish_run(string tag);
    int n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check(halted, {tag, " R9 halted reached"}, halted, 1);
    repeat (5) @(negedge clk);
    check(halted, "R9 halt holds", halted, 1);
    check(exp_q.size() == 0, {tag, " all expected events seen"}, exp_q.size(), 0);
    check(!multi, "R11 single strobe per cycle", multi, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Test A: worked example, R2 and R3
    start();
    mem['h300] = 16'h1940; mem['h301] = 16'h5941; mem['h302] = 16'h2941;
    mem['h303] = 16'h0000; mem['h940] = 16'h0003; mem['h941] = 16'h0002;
    expect_ev(K_MEM, 12'h941, 16'h0005, "R2 R3 store of sum");
    @(negedge clk) rst_n = 1'b1;
    finish_run("R3");
    check(mem['h941] == 16'h0005, "R3 result word", mem['h941], 16'h0005);

    // Test B: I/O, wrap-around add, undefined opcode
    start();
    mem['h300] = 16'h3005; mem['h301] = 16'h5940; mem['h302] = 16'h8123;
    mem['h303] = 16'h7009; mem['h304] = 16'h2941; mem['h305] = 16'h0000;
    mem['h940] = 16'h7000;
    expect_ev(K_IN,  12'h005, 16'h0000, "R4 device read strobe");
    expect_ev(K_OUT, 12'h009, 16'h1005, "R5 R10 device write of wrapped sum");
    expect_ev(K_MEM, 12'h941, 16'h1005, "R3 R10 store of wrapped sum");
    @(negedge clk) rst_n = 1'b1;
    finish_run("R4");
    check(mem['h123] == 16'h0000, "R8 undefined opcode left memory", mem['h123], 0);
    check(mem['h941] == 16'h1005, "R10 stored sum", mem['h941], 16'h1005);

    // Test C: interrupt entry, masking, return, immediate re-entry
    start();
    mem['h300] = 16'h3002; mem['h301] = 16'h7004; mem['h302] = 16'h0000;
    mem['h100] = 16'h1200; mem['h101] = 16'h7006; mem['h102] = 16'hF000;
    mem['h200] = 16'h0BEE;
    expect_ev(K_IN,  12'h002, 16'h0000, "R4 read before interrupt");
    for (int k = 0; k < 2; k++) begin
      expect_ev(K_ACK, 12'h000, 16'h0000, "R6 R7 acknowledge");
      expect_ev(K_MEM, 12'h0FE, 16'h0301, "R6 return address saved");
      expect_ev(K_MEM, 12'h0FF, 16'hA002, "R6 accumulator saved");
      expect_ev(K_OUT, 12'h006, 16'h0BEE, "R7 handler runs masked");
    end
    expect_ev(K_OUT, 12'h004, 16'hA002, "R7 accumulator restored");
    irq = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    begin
      int n = 0;
      while (acks < 2 && n < 3000) begin @(negedge clk); n++; end
    end
    irq = 1'b0;
    finish_run("R6");
    check(acks == 2, "R7 acknowledge count", acks, 2);
    check(mem['h0FE] == 16'h0301, "R6 save word PC", mem['h0FE], 16'h0301);
    check(mem['h0FF] == 16'hA002, "R6 save word AC", mem['h0FF], 16'hA002);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule